// File: doc/BRIEF.md
# Segment Register Address Translator

This block converts segment:offset addresses into flat linear addresses. It keeps six segment registers. Each register holds a hidden copy of a segment descriptor. Software installs a segment by naming a register and handing over a 16-bit selector. The top 13 bits of the selector index a descriptor table in memory, so the table can hold up to 8192 entries. The block reads the 8-byte entry from that table over a simple read port and stores the decoded base, limit and rights in the chosen register.

From then on, every translation request names one of the six registers and supplies an offset. The block works out the result from the hidden copy alone and never reads memory for it. It checks the offset against the segment limit and checks a write against the writable right. If both checks pass, it returns base plus offset one cycle later. If a check fails, it reports a fault code instead.

After reset, all six registers describe a flat segment: base zero, with a limit that covers the whole 32-bit space. In that state the linear address equals the offset.

Top module: `seg_xlat_unit`

## Requirements
- R1: After reset, every register holds a flat descriptor: base 0, limit field 0xFFFFF, writable and present. A translation through any register then returns the offset unchanged as the linear address. After reset, `ld_ready` is high and `mem_req`, `res_ok` and `res_fault` are low.
- R2: A load with selector `s` reads the word at `tbl_base + s[15:3]*8` first and then the word at that address plus 4. Selector bits [2:0] have no effect on either address.
- R3: The first descriptor word is the 32-bit base. In the second word, bits [19:0] are the limit in 4 KiB units, bit 20 is the writable flag and bit 21 is the present flag. `ld_done` pulses once for each load. For a present descriptor, `ld_fault` is low and the new descriptor governs all later translations through that register.
- R4: A translation accepted on a clock edge (`xl_valid` and `xl_ready` both high) drives `res_ok` high for exactly one cycle after that edge, with `res_lin` equal to the cached base plus `xl_off`, modulo 2^32. A translation never issues a memory read.
- R5: If the offset is greater than `{limit, 12'hFFF}`, the result is `res_fault` with `res_code` 1 and `res_ok` stays low. An offset exactly equal to that bound passes.
- R6: A write (`xl_write` = 1) through a register whose descriptor is not writable gives `res_fault` with `res_code` 2. A read through the same register passes.
- R7: Loading a descriptor whose present flag is clear raises `ld_fault` together with `ld_done`, and the register keeps its previous descriptor.
- R8: While a descriptor fetch for a register is in progress, `xl_ready` is low for requests that name that register. Requests that name any other register are accepted every cycle, including the cycle in which the fetch completes.
- R9: Register codes 6 and 7 are invalid. A translation that names one of them gives `res_fault` with `res_code` 3. A load that names one of them ends with `ld_fault` and changes no register.
- R10: When more than one check fails, the reported code follows a fixed priority: invalid register (3) first, then limit (1), then write protection (2).
- R11: `ld_ready` is low from the acceptance of a load until its fetch completes. `mem_req` and `mem_addr` stay stable until `mem_rvalid` answers the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_base | input | 32 | Byte address of the descriptor table |
| ld_valid | input | 1 | Request to load a selector |
| ld_seg | input | 3 | Target register of the load |
| ld_sel | input | 16 | Selector; bits [15:3] are the table index |
| ld_ready | output | 1 | High when a load can be accepted |
| ld_done | output | 1 | One-cycle pulse when a load ends |
| ld_fault | output | 1 | Valid with ld_done: descriptor absent or register invalid |
| xl_valid | input | 1 | Translation request |
| xl_seg | input | 3 | Register used by the translation |
| xl_off | input | 32 | Offset part of the logical address |
| xl_write | input | 1 | Access is a write |
| xl_ready | output | 1 | Low while the named register is being fetched |
| res_ok | output | 1 | Linear address valid, one cycle pulse |
| res_fault | output | 1 | Translation faulted, one cycle pulse |
| res_code | output | 2 | Fault code: 1 limit, 2 write protect, 3 invalid register |
| res_lin | output | 32 | Linear address |
| mem_req | output | 1 | Descriptor word read request |
| mem_addr | output | 32 | Descriptor word byte address |
| mem_rvalid | input | 1 | Read data valid; ends the request |
| mem_rdata | input | 32 | Read data |

## Verification
Two events can fall on the same clock edge: the fetch writes a new descriptor into one register, and a translation through another register is accepted. The bench starts a load on one register. While that load is in progress, it holds a translation request on a flat register every cycle, long enough to run across the edge where the fetch completes. Each of those results must come back on time and equal to its offset. Just before that, a request on the register being loaded must see `xl_ready` low. The first translation on that register after the load must use the newly fetched base.

// File: rtl/seg_xlat_pkg.sv
package seg_xlat_pkg;

  localparam int ADDR_W   = 32;
  localparam int NUM_SEG  = 6;
  localparam int SEG_W    = 3;
  localparam int IDX_W    = 13;
  localparam int SEL_W    = IDX_W + 3;
  localparam int LIM_W    = 20;
  localparam int GRAN_SH  = ADDR_W - LIM_W;
  localparam int WR_BIT   = 20;
  localparam int PRES_BIT = 21;
  localparam int WORD_BYTES = 4;

  typedef struct packed {
    logic [ADDR_W-1:0] base;
    logic [LIM_W-1:0]  limit;
    logic              wr;
    logic              pres;
  } seg_desc_t;

  localparam seg_desc_t DESC_FLAT = '{base: '0, limit: '1, wr: 1'b1, pres: 1'b1};

  typedef enum logic [1:0] {
    FC_NONE   = 2'd0,
    FC_LIMIT  = 2'd1,
    FC_WPROT  = 2'd2,
    FC_BADSEG = 2'd3
  } fault_code_e;

endpackage

// File: rtl/seg_fetch_fsm.sv
module seg_fetch_fsm
  import seg_xlat_pkg::*;
#(
  parameter int P_ADDR_W  = ADDR_W,
  parameter int P_NUM_SEG = NUM_SEG,
  parameter int P_SEG_W   = SEG_W,
  parameter int P_SEL_W   = SEL_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [P_ADDR_W-1:0]  tbl_base,
  input  logic                 ld_valid,
  input  logic [P_SEG_W-1:0]   ld_seg,
  input  logic [P_SEL_W-1:0]   ld_sel,
  output logic                 ld_ready,
  output logic                 ld_done,
  output logic                 ld_fault,
  output logic                 busy,
  output logic [P_SEG_W-1:0]   busy_seg,
  output logic                 mem_req,
  output logic [P_ADDR_W-1:0]  mem_addr,
  input  logic                 mem_rvalid,
  input  logic [P_ADDR_W-1:0]  mem_rdata,
  output logic                 wr_en,
  output logic [P_SEG_W-1:0]   wr_seg,
  output seg_desc_t            wr_desc
);

  typedef enum logic [1:0] {F_IDLE, F_WORD0, F_WORD1} fstate_e;

  localparam int ENTRY_SH = 3;

  fstate_e               st_q, st_d;
  logic [P_SEG_W-1:0]    seg_q, seg_d;
  logic [P_ADDR_W-1:0]   addr_q, addr_d;
  logic [P_ADDR_W-1:0]   base_q, base_d;
  logic                  done_d, fault_d;
  logic                  done_q, fault_q;
  logic                  seg_bad;
  logic                  addr_en, base_en, seg_en;
  logic [P_SEL_W-1:0]    entry_off;

  assign entry_off = {ld_sel[P_SEL_W-1:ENTRY_SH], {ENTRY_SH{1'b0}}};
  assign seg_bad   = (32'(seg_q) >= P_NUM_SEG);

  always_comb begin
    st_d    = st_q;
    seg_d   = seg_q;
    addr_d  = addr_q;
    base_d  = base_q;
    done_d  = 1'b0;
    fault_d = 1'b0;
    wr_en   = 1'b0;
    addr_en = 1'b0;
    base_en = 1'b0;
    seg_en  = 1'b0;
    case (st_q)
      F_IDLE: begin
        if (ld_valid) begin
          st_d    = F_WORD0;
          seg_d   = ld_seg;
          seg_en  = 1'b1;
          addr_d  = tbl_base + P_ADDR_W'(entry_off);
          addr_en = 1'b1;
        end
      end
      F_WORD0: begin
        if (mem_rvalid) begin
          base_d  = mem_rdata;
          base_en = 1'b1;
          addr_d  = addr_q + P_ADDR_W'(WORD_BYTES);
          addr_en = 1'b1;
          st_d    = F_WORD1;
        end
      end
      F_WORD1: begin
        if (mem_rvalid) begin
          st_d    = F_IDLE;
          done_d  = 1'b1;
          fault_d = !mem_rdata[PRES_BIT] || seg_bad;
          wr_en   = mem_rdata[PRES_BIT] && !seg_bad;
        end
      end
      default: st_d = F_IDLE;
    endcase
  end

  always_comb begin
    wr_desc.base  = base_q;
    wr_desc.limit = mem_rdata[LIM_W-1:0];
    wr_desc.wr    = mem_rdata[WR_BIT];
    wr_desc.pres  = mem_rdata[PRES_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= F_IDLE;
      seg_q   <= '0;
      addr_q  <= '0;
      base_q  <= '0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      done_q  <= done_d;
      fault_q <= fault_d;
      if (seg_en)  seg_q  <= seg_d;
      if (addr_en) addr_q <= addr_d;
      if (base_en) base_q <= base_d;
    end
  end

  assign ld_ready = (st_q == F_IDLE);
  assign busy     = (st_q != F_IDLE);
  assign busy_seg = seg_q;
  assign mem_req  = (st_q != F_IDLE);
  assign mem_addr = addr_q;
  assign wr_seg   = seg_q;
  assign ld_done  = done_q;
  assign ld_fault = fault_q;

  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

  a_r2_second_word: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == F_WORD0 && mem_rvalid) |=> (mem_addr == $past(mem_addr) + P_ADDR_W'(WORD_BYTES)));

  a_r7_fault_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en) |=> (ld_done && !ld_fault));

endmodule

// File: rtl/seg_desc_bank.sv
module seg_desc_bank
  import seg_xlat_pkg::*;
#(
  parameter int P_NUM_SEG = NUM_SEG,
  parameter int P_SEG_W   = SEG_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [P_SEG_W-1:0]  wr_seg,
  input  seg_desc_t           wr_desc,
  input  logic [P_SEG_W-1:0]  rd_seg,
  output seg_desc_t           rd_desc
);

  seg_desc_t regs [P_NUM_SEG];

  for (genvar g = 0; g < P_NUM_SEG; g++) begin : g_seg
    logic hit;
    assign hit = wr_en && (wr_seg == P_SEG_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs[g] <= DESC_FLAT;
      end else if (hit) begin
        regs[g] <= wr_desc;
      end
    end
  end

  always_comb begin
    rd_desc = DESC_FLAT;
    for (int i = 0; i < P_NUM_SEG; i++) begin
      if (rd_seg == P_SEG_W'(i)) rd_desc = regs[i];
    end
  end

  a_r3_only_present_stored: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wr_desc.pres);

endmodule

// File: rtl/seg_xlate_check.sv
module seg_xlate_check
  import seg_xlat_pkg::*;
#(
  parameter int P_ADDR_W = ADDR_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                acc,
  input  logic                seg_bad,
  input  seg_desc_t           desc,
  input  logic [P_ADDR_W-1:0] off,
  input  logic                write,
  output logic                res_ok,
  output logic                res_fault,
  output logic [1:0]          res_code,
  output logic [P_ADDR_W-1:0] res_lin
);

  logic [P_ADDR_W-1:0] eff_lim;
  logic                over, wprot;
  fault_code_e         code_d;
  logic                ok_d, fault_d;
  logic [P_ADDR_W-1:0] lin_d;

  logic                ok_q, fault_q;
  fault_code_e         code_q;
  logic [P_ADDR_W-1:0] lin_q;

  assign eff_lim = P_ADDR_W'({desc.limit, {GRAN_SH{1'b1}}});

  always_comb begin
    over  = (off > eff_lim);
    wprot = write && !desc.wr;
    if (seg_bad)    code_d = FC_BADSEG;
    else if (over)  code_d = FC_LIMIT;
    else if (wprot) code_d = FC_WPROT;
    else            code_d = FC_NONE;
    ok_d    = acc && (code_d == FC_NONE);
    fault_d = acc && (code_d != FC_NONE);
    lin_d   = desc.base + off;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ok_q    <= 1'b0;
      fault_q <= 1'b0;
      code_q  <= FC_NONE;
      lin_q   <= '0;
    end else begin
      ok_q    <= ok_d;
      fault_q <= fault_d;
      if (acc) begin
        code_q <= code_d;
        lin_q  <= lin_d;
      end
    end
  end

  assign res_ok    = ok_q;
  assign res_fault = fault_q;
  assign res_code  = code_q;
  assign res_lin   = lin_q;

  a_r5_ok_or_fault: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_ok && res_fault));

  a_r4_result_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (res_ok || res_fault) |-> $past(acc));

endmodule

// File: rtl/seg_xlat_unit.sv
module seg_xlat_unit
  import seg_xlat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       tbl_base,
  input  logic              ld_valid,
  input  logic [2:0]        ld_seg,
  input  logic [15:0]       ld_sel,
  output logic              ld_ready,
  output logic              ld_done,
  output logic              ld_fault,
  input  logic              xl_valid,
  input  logic [2:0]        xl_seg,
  input  logic [31:0]       xl_off,
  input  logic              xl_write,
  output logic              xl_ready,
  output logic              res_ok,
  output logic              res_fault,
  output logic [1:0]        res_code,
  output logic [31:0]       res_lin,
  output logic              mem_req,
  output logic [31:0]       mem_addr,
  input  logic              mem_rvalid,
  input  logic [31:0]       mem_rdata
);

  logic             busy;
  logic [SEG_W-1:0] busy_seg;
  logic             wr_en;
  logic [SEG_W-1:0] wr_seg;
  seg_desc_t        wr_desc;
  seg_desc_t        rd_desc;
  logic             acc;
  logic             seg_bad;

  seg_fetch_fsm u_fetch (
    .clk        (clk),
    .rst_n      (rst_n),
    .tbl_base   (tbl_base),
    .ld_valid   (ld_valid),
    .ld_seg     (ld_seg),
    .ld_sel     (ld_sel),
    .ld_ready   (ld_ready),
    .ld_done    (ld_done),
    .ld_fault   (ld_fault),
    .busy       (busy),
    .busy_seg   (busy_seg),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_rvalid (mem_rvalid),
    .mem_rdata  (mem_rdata),
    .wr_en      (wr_en),
    .wr_seg     (wr_seg),
    .wr_desc    (wr_desc)
  );

  seg_desc_bank u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_seg  (wr_seg),
    .wr_desc (wr_desc),
    .rd_seg  (xl_seg),
    .rd_desc (rd_desc)
  );

  assign xl_ready = !(busy && (busy_seg == xl_seg));
  assign acc      = xl_valid && xl_ready;
  assign seg_bad  = (32'(xl_seg) >= NUM_SEG);

  seg_xlate_check u_check (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc       (acc),
    .seg_bad   (seg_bad),
    .desc      (rd_desc),
    .off       (xl_off),
    .write     (xl_write),
    .res_ok    (res_ok),
    .res_fault (res_fault),
    .res_code  (res_code),
    .res_lin   (res_lin)
  );

  a_r9_badseg_code: assert property (@(posedge clk) disable iff (!rst_n)
    (res_fault && res_code == 2'd3) |-> ($past(xl_seg) >= 3'd6));

  a_r8_no_result_while_own_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && xl_valid && xl_seg == busy_seg && !(res_ok || res_fault)) |=> !(res_ok || res_fault));

endmodule

// File: tb/tb_seg_xlat_unit.sv
module tb_seg_xlat_unit;

  logic        clk;
  logic        rst_n;
  logic [31:0] tbl_base;
  logic        ld_valid;
  logic [2:0]  ld_seg;
  logic [15:0] ld_sel;
  logic        ld_ready, ld_done, ld_fault;
  logic        xl_valid;
  logic [2:0]  xl_seg;
  logic [31:0] xl_off;
  logic        xl_write;
  logic        xl_ready;
  logic        res_ok, res_fault;
  logic [1:0]  res_code;
  logic [31:0] res_lin;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid;
  logic [31:0] mem_rdata;

  seg_xlat_unit dut (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct {
    bit        ok;
    bit [1:0]  code;
    bit [31:0] lin;
    string     tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   fails  = 0;
  int   reads  = 0;
  bit [31:0] addr_log[$];

  bit [31:0] mem [0:255];
  int        lat_cnt;

  bit [31:0] e_base [0:7];
  bit [19:0] e_lim  [0:7];
  bit        e_wr   [0:7];
  bit        e_pres [0:7];

  bit [31:0] m_base [0:5];
  bit [19:0] m_lim  [0:5];
  bit        m_wr   [0:5];

  task automatic chk(input bit cond, input string tag, input bit [63:0] act, input bit [63:0] expv);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_rvalid <= 1'b0;
      mem_rdata  <= '0;
      lat_cnt    <= 0;
    end else if (mem_rvalid) begin
      mem_rvalid <= 1'b0;
      lat_cnt    <= 0;
    end else if (mem_req) begin
      if (lat_cnt == 2) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= mem[mem_addr[9:2]];
      end else begin
        lat_cnt <= lat_cnt + 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && mem_rvalid) begin
      reads++;
      addr_log.push_back(mem_addr);
    end
  end

  always @(negedge clk) begin
    if (rst_n && (res_ok || res_fault)) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R4 unexpected result", {63'd0, res_ok}, 64'd0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(res_ok == e.ok, {e.tag, " ok"}, {63'd0, res_ok}, {63'd0, e.ok});
        if (e.ok)
          chk(res_lin == e.lin, {e.tag, " lin"}, {32'd0, res_lin}, {32'd0, e.lin});
        else
          chk(res_code == e.code, {e.tag, " code"}, {62'd0, res_code}, {62'd0, e.code});
      end
    end
  end

  function automatic exp_t predict(input int seg, input bit [31:0] off, input bit wr, input string tag);
    exp_t e;
    bit [31:0] lim;
    e.tag = tag;
    e.lin = 0;
    if (seg >= 6) begin
      e.ok = 0; e.code = 3;
    end else begin
      lim = {m_lim[seg], 12'hFFF};
      if (off > lim) begin
        e.ok = 0; e.code = 1;
      end else if (wr && !m_wr[seg]) begin
        e.ok = 0; e.code = 2;
      end else begin
        e.ok = 1; e.code = 0; e.lin = m_base[seg] + off;
      end
    end
    return e;
  endfunction

  task automatic xlate(input int seg, input bit [31:0] off, input bit wr, input string tag);
    @(negedge clk);
    xl_valid = 1'b1;
    xl_seg   = 3'(seg);
    xl_off   = off;
    xl_write = wr;
    #1;
    while (!xl_ready) begin
      @(negedge clk);
      #1;
    end
    exp_q.push_back(predict(seg, off, wr, tag));
    @(posedge clk);
  endtask

  task automatic xl_idle();
    @(negedge clk);
    xl_valid = 1'b0;
  endtask

  task automatic do_load(input int seg, input int idx, input bit [2:0] low, input bit exp_fault, input string tag);
    @(negedge clk);
    while (!ld_ready) @(negedge clk);
    addr_log.delete();
    ld_valid = 1'b1;
    ld_seg   = 3'(seg);
    ld_sel   = {13'(idx), low};
    if (!exp_fault) begin
      m_base[seg] = e_base[idx];
      m_lim[seg]  = e_lim[idx];
      m_wr[seg]   = e_wr[idx];
    end
    @(posedge clk);
    @(negedge clk);
    ld_valid = 1'b0;
    chk(!ld_ready, "R11 ld_ready low during fetch", {63'd0, ld_ready}, 64'd0);
    while (!ld_done) @(negedge clk);
    chk(ld_fault == exp_fault, {tag, " ld_fault"}, {63'd0, ld_fault}, {63'd0, exp_fault});
    chk(addr_log.size() == 2, "R2 two reads", 64'(addr_log.size()), 64'd2);
    if (addr_log.size() == 2) begin
      chk(addr_log[0] == 32'h100 + 32'(idx) * 8, "R2 first addr", {32'd0, addr_log[0]}, 64'h100 + 64'(idx) * 8);
      chk(addr_log[1] == 32'h104 + 32'(idx) * 8, "R2 second addr", {32'd0, addr_log[1]}, 64'h104 + 64'(idx) * 8);
    end
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int rd_before;
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    for (int i = 0; i < 8; i++) begin
      e_base[i] = 0; e_lim[i] = 0; e_wr[i] = 0; e_pres[i] = 0;
    end
    e_base[1] = 32'h4000_0000; e_lim[1] = 20'h2;     e_wr[1] = 1; e_pres[1] = 1;
    e_base[2] = 32'h0001_0000; e_lim[2] = 20'hFFFFF; e_wr[2] = 0; e_pres[2] = 1;
    e_base[3] = 32'h7777_0000; e_lim[3] = 20'h1;     e_wr[3] = 1; e_pres[3] = 0;
    e_base[5] = 32'h8000_0000; e_lim[5] = 20'h0;     e_wr[5] = 1; e_pres[5] = 1;
    e_base[6] = 32'h0000_0100; e_lim[6] = 20'h0;     e_wr[6] = 0; e_pres[6] = 1;
    for (int i = 0; i < 8; i++) begin
      mem[64 + 2*i]     = e_base[i];
      mem[64 + 2*i + 1] = {10'd0, e_pres[i], e_wr[i], e_lim[i]};
    end
    for (int s = 0; s < 6; s++) begin
      m_base[s] = 0; m_lim[s] = 20'hFFFFF; m_wr[s] = 1;
    end

    tbl_base = 32'h100;
    ld_valid = 0; ld_seg = 0; ld_sel = 0;
    xl_valid = 0; xl_seg = 0; xl_off = 0; xl_write = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    chk(ld_ready && !mem_req && !res_ok && !res_fault, "R1 reset outputs",
        {60'd0, ld_ready, mem_req, res_ok, res_fault}, 64'h8);

    for (int s = 0; s < 6; s++) xlate(s, 32'h1234_5678 + 32'(s), s[0], "R1 flat");
    xlate(0, 32'hFFFF_FFFF, 1'b1, "R1 flat top");
    xl_idle();

    do_load(1, 1, 3'b101, 1'b0, "R3 load present");
    rd_before = reads;
    xlate(1, 32'h10, 1'b0, "R4 base plus offset");
    xlate(1, 32'h2FFF, 1'b1, "R5 at limit");
    xlate(1, 32'h3000, 1'b0, "R5 over limit");
    xl_idle();
    repeat (4) @(negedge clk);
    chk(reads == rd_before, "R4 no memory read", 64'(reads), 64'(rd_before));

    do_load(4, 2, 3'b000, 1'b0, "R3 load read-only");
    xlate(4, 32'h20, 1'b1, "R6 write protect");
    xlate(4, 32'h20, 1'b0, "R6 read allowed");
    xl_idle();

    do_load(1, 3, 3'b000, 1'b1, "R7 absent");
    xlate(1, 32'h10, 1'b0, "R7 old descriptor kept");
    xl_idle();

    xlate(6, 32'h0, 1'b0, "R9 code 6");
    xlate(7, 32'h5, 1'b1, "R9 code 7");
    xl_idle();

    do_load(7, 1, 3'b000, 1'b1, "R9 load invalid register");

    do_load(5, 6, 3'b000, 1'b0, "R3 load small");
    xlate(5, 32'h2000, 1'b1, "R10 limit over write");
    xlate(5, 32'h10, 1'b1, "R10 write only");
    xlate(7, 32'hFFFF_0000, 1'b1, "R10 badseg over all");
    xl_idle();

    fork
      do_load(2, 5, 3'b011, 1'b0, "R8 load during traffic");
      begin
        @(negedge clk);
        while (ld_ready) @(negedge clk);
        xl_valid = 1'b1; xl_seg = 3'd2; xl_off = 32'h4; xl_write = 1'b0;
        #1;
        chk(!xl_ready, "R8 stall same register", {63'd0, xl_ready}, 64'd0);
        for (int k = 0; k < 14; k++) xlate(3, 32'h100 + 32'(k), 1'b0, "R8 other register proceeds");
        xl_idle();
      end
    join
    xlate(2, 32'h4, 1'b0, "R8 new descriptor after fetch");
    xl_idle();

    repeat (6) @(negedge clk);
    chk(exp_q.size() == 0, "R4 all results returned", 64'(exp_q.size()), 64'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule